// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns a single serial input line into characters. A frame starts with a low start bit on a line that idles high. Then come 5 to 9 data bits, least significant first. An optional parity bit follows, and then one or two stop bits. The data length, the parity mode and the stop-bit count are run-time settings, and they match the settings of the transmitter on the other end of the line. Each finished character is placed in a single holding register. It is offered on a valid/ready output together with its parity-error and framing-error flags.

There are two timing modes. In asynchronous mode the receiver uses a one-cycle tick at sixteen times the bit rate. It finds the falling edge of the start bit and takes three votes around the middle of every bit. In synchronous mode it ignores the tick and takes one sample per bit on an external transfer clock. A polarity setting picks the clock edge. Both inputs pass through a synchronizer into the system clock domain.

The output is held while the consumer holds back. If `out_valid` is high and `out_ready` is low, the data and both flags stay unchanged. A transfer happens on any rising `clk` edge where both signals are high. If a further character completes while the held one has not been taken, the new character is dropped and `overrun` is set. `overrun` stays set until the held character is accepted.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `out_valid` and `overrun` are both 0.
- R2: Asynchronous mode (`cfg_sync`=0) has four rules.
  - A start is detected on an `os_tick` where the synchronized line is low.
  - Ticks 7, 8 and 9 after the detecting tick are each sampled, and the bit value is the majority of the three samples.
  - If that majority is high for the start bit, the receiver returns to idle and produces no character.
  - Every later bit lasts 16 ticks.
- R3: Data bits are taken least significant bit first, and their count is `cfg_data_len`. Values below 5 act as 5, and values above 9 act as 9. The character is right-aligned in `out_data[8:0]`, and the unused upper bits are 0.
- R4: `cfg_parity` sets the parity mode: 2'b00 and 2'b01 mean no parity, 2'b10 means even parity and 2'b11 means odd parity. When parity is on, the bit after the data is the parity bit. `out_par_err` is 1 exactly when the data bits plus that parity bit hold an odd number of ones in even mode, or an even number of ones in odd mode. `out_par_err` is always 0 when parity is off.
- R5: `out_frm_err` is 1 when the first stop bit is sampled low. When `cfg_two_stop`=1, a second bit time is spent in the frame, but its value is never checked.
- R6: Synchronous mode (`cfg_sync`=1) takes one bit per edge of `xfer_clk`. With `cfg_clk_pol`=0 the receiver samples on the falling edge, and with `cfg_clk_pol`=1 on the rising edge.
- R7: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_par_err` and `out_frm_err` hold steady, and `out_valid` stays high. The two flags belong to the character shown with them.
- R8: `overrun` becomes 1 when a character completes while `out_valid`=1 and `out_ready`=0. In that case the older character is kept and the new one is dropped. `overrun` returns to 0 on the next accepted transfer.
- R9: The format settings are captured when the start bit is accepted and are used for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sync | input | 1 | 0: asynchronous with ticks, 1: synchronous with `xfer_clk` |
| cfg_clk_pol | input | 1 | Sampling edge in synchronous mode: 0 falling, 1 rising |
| cfg_data_len | input | 4 | Number of data bits, 5 to 9 (values outside the range are clamped) |
| cfg_parity | input | 2 | 00/01 none, 10 even, 11 odd |
| cfg_two_stop | input | 1 | 1: frame carries a second stop bit |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| xfer_clk | input | 1 | External transfer clock for synchronous mode |
| rx_line | input | 1 | Serial input, idles high |
| out_valid | output | 1 | A received character is held |
| out_ready | input | 1 | The consumer accepts the held character |
| out_data | output | 9 | Received character, right-aligned and zero-extended |
| out_par_err | output | 1 | Parity mismatch for the held character |
| out_frm_err | output | 1 | First stop bit was low for the held character |
| overrun | output | 1 | A character was lost while the output was blocked |

## Verification
In asynchronous mode, `out_valid` rises two `clk` cycles after the tick that ends the vote on the first stop bit. In synchronous mode, it rises four `clk` cycles after the sampling edge of `xfer_clk` reaches the pin: two synchronizer stages, the frame register and the holding register. The bench always idles the line for at least one full bit after each stop bit. It then requires its expected-item queue to be empty, so a late or missing character is reported. All outputs are sampled on the falling edge of `clk`. Back-pressure, overrun and false-start cases are checked in the quiet interval after the stimulus has ended.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MIN_BITS = 5;
  localparam int MAX_BITS = 9;

  typedef enum logic [1:0] {
    PAR_OFF   = 2'b00,
    PAR_OFF_B = 2'b01,
    PAR_EVEN  = 2'b10,
    PAR_ODD   = 2'b11
  } parity_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                perr;
    logic                ferr;
  } rx_char_t;

  function automatic logic [3:0] clamp_len(input logic [3:0] l);
    if (l < 4'(MIN_BITS)) return 4'(MIN_BITS);
    if (l > 4'(MAX_BITS)) return 4'(MAX_BITS);
    return l;
  endfunction
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int                WIDTH   = 2,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rxf_async_sampler.sv
module rxf_async_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic line,
  input  logic frame_done,
  output logic bit_stb,
  output logic bit_val
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic          active;
  logic          first;
  logic [CW-1:0] cnt;
  logic [1:0]    votes;
  logic          maj;

  assign maj     = (votes[0] & votes[1]) | (votes[0] & line) | (votes[1] & line);
  assign bit_stb = active && tick && (cnt == CW'(MID + 1));
  assign bit_val = maj;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      first  <= 1'b0;
      cnt    <= '0;
      votes  <= 2'b11;
    end else if (!en) begin
      active <= 1'b0;
    end else if (!active) begin
      if (tick && !line) begin
        active <= 1'b1;
        first  <= 1'b1;
        cnt    <= CW'(1);
      end
    end else if (frame_done) begin
      active <= 1'b0;
    end else if (tick) begin
      cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(MID - 1)) votes[0] <= line;
      if (cnt == CW'(MID))     votes[1] <= line;
      if (cnt == CW'(MID + 1)) begin
        first <= 1'b0;
        if (first && maj) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxf_edge_sampler.sv
module rxf_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pol,
  input  logic xclk_s,
  input  logic line_s,
  output logic bit_stb,
  output logic bit_val
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= xclk_s;

  assign bit_stb = en && (pol ? (xclk_s && !prev) : (!xclk_s && prev));
  assign bit_val = line_s;
endmodule

// File: rtl/rxf_frame_fsm.sv
module rxf_frame_fsm
  import rxf_pkg::*;
#(
  parameter int NBITS = MAX_BITS
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       bit_val,
  input  logic [3:0] cfg_len,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_two_stop,
  output logic       frame_done,
  output logic       chr_stb,
  output rx_char_t   chr
);
  localparam int LW = $clog2(NBITS + 1);

  rx_state_e        state;
  logic [LW-1:0]    idx;
  logic [3:0]       len_q;
  logic             par_en_q, par_odd_q, two_q;
  logic [NBITS-1:0] shreg;
  logic             par_acc, perr_q;
  parity_e          pmode;

  assign pmode      = parity_e'(cfg_parity);
  assign frame_done = bit_stb && ((state == ST_STOP1 && !two_q) || state == ST_STOP2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      len_q     <= 4'(MIN_BITS);
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      two_q     <= 1'b0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      perr_q    <= 1'b0;
      chr_stb   <= 1'b0;
      chr       <= '0;
    end else begin
      chr_stb <= 1'b0;
      if (bit_stb) begin
        unique case (state)
          ST_IDLE: if (!bit_val) begin
            state     <= ST_DATA;
            idx       <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            perr_q    <= 1'b0;
            len_q     <= clamp_len(cfg_len);
            par_en_q  <= (pmode == PAR_EVEN) || (pmode == PAR_ODD);
            par_odd_q <= (pmode == PAR_ODD);
            two_q     <= cfg_two_stop;
          end
          ST_DATA: begin
            shreg[idx] <= bit_val;
            par_acc    <= par_acc ^ bit_val;
            idx        <= idx + 1'b1;
            if (idx == LW'(len_q - 4'd1))
              state <= par_en_q ? ST_PAR : ST_STOP1;
          end
          ST_PAR: begin
            perr_q <= par_acc ^ bit_val ^ par_odd_q;
            state  <= ST_STOP1;
          end
          ST_STOP1: begin
            chr_stb   <= 1'b1;
            chr.data  <= shreg;
            chr.perr  <= par_en_q & perr_q;
            chr.ferr  <= !bit_val;
            state     <= two_q ? ST_STOP2 : ST_IDLE;
          end
          ST_STOP2: state <= ST_IDLE;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxf_out_stage.sv
module rxf_out_stage
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     chr_stb,
  input  rx_char_t chr_in,
  input  logic     ready,
  output logic     valid,
  output rx_char_t chr_out,
  output logic     ovr
);
  logic take;
  assign take = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      ovr     <= 1'b0;
      chr_out <= '0;
    end else begin
      if (chr_stb && (!valid || ready)) begin
        chr_out <= chr_in;
        valid   <= 1'b1;
      end else if (take) begin
        valid <= 1'b0;
      end
      if (take)                 ovr <= 1'b0;
      else if (chr_stb && valid) ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import rxf_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_sync,
  input  logic                cfg_clk_pol,
  input  logic [3:0]          cfg_data_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic                os_tick,
  input  logic                xfer_clk,
  input  logic                rx_line,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [MAX_BITS-1:0] out_data,
  output logic                out_par_err,
  output logic                out_frm_err,
  output logic                overrun
);
  logic     xclk_s, line_s;
  logic     a_stb, a_val, e_stb, e_val;
  logic     bit_stb, bit_val;
  logic     frame_done, chr_stb;
  rx_char_t chr, held;

  rxf_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({xfer_clk, rx_line}), .q({xclk_s, line_s})
  );

  rxf_async_sampler #(.OSR(OSR)) u_async (
    .clk(clk), .rst_n(rst_n), .en(!cfg_sync), .tick(os_tick), .line(line_s),
    .frame_done(frame_done), .bit_stb(a_stb), .bit_val(a_val)
  );

  rxf_edge_sampler u_edge (
    .clk(clk), .rst_n(rst_n), .en(cfg_sync), .pol(cfg_clk_pol),
    .xclk_s(xclk_s), .line_s(line_s), .bit_stb(e_stb), .bit_val(e_val)
  );

  assign bit_stb = cfg_sync ? e_stb : a_stb;
  assign bit_val = cfg_sync ? e_val : a_val;

  rxf_frame_fsm #(.NBITS(MAX_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .cfg_len(cfg_data_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .frame_done(frame_done), .chr_stb(chr_stb), .chr(chr)
  );

  rxf_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .chr_stb(chr_stb), .chr_in(chr),
    .ready(out_ready), .valid(out_valid), .chr_out(held), .ovr(overrun)
  );

  assign out_data    = held.data;
  assign out_par_err = held.perr;
  assign out_frm_err = held.ferr;
endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [8:0] out_data,
  input logic       out_par_err,
  input logic       out_frm_err,
  input logic       overrun,
  input logic       chr_stb,
  input logic       bit_stb,
  input logic       cfg_sync,
  input logic       cfg_clk_pol,
  input logic       xclk_s
);
  AST_HOLD_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_par_err) && $stable(out_frm_err)); // R7

  AST_CHAR_REACHES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    chr_stb |=> out_valid); // R7

  AST_OVERRUN_NEEDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> out_valid && $past(out_valid) && !$past(out_ready)); // R8

  AST_OVERRUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !overrun); // R8

  AST_SYNC_EDGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sync && bit_stb |-> (xclk_s == cfg_clk_pol) && (xclk_s != $past(xclk_s))); // R6
endmodule

bind serial_frame_rx serial_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_par_err(out_par_err), .out_frm_err(out_frm_err),
  .overrun(overrun), .chr_stb(chr_stb), .bit_stb(bit_stb), .cfg_sync(cfg_sync),
  .cfg_clk_pol(cfg_clk_pol), .xclk_s(xclk_s)
);

// File: tb/tb_serial_frame_rx.sv
module tb_serial_frame_rx;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;
  localparam int HALF_X   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_sync = 1'b0, cfg_clk_pol = 1'b0, cfg_two_stop = 1'b0;
  logic [3:0] cfg_data_len = 4'd8;
  logic [1:0] cfg_parity = 2'b00;
  logic       os_tick = 1'b0, xfer_clk = 1'b1, rx_line = 1'b1, out_ready = 1'b1;
  logic       out_valid, out_par_err, out_frm_err, overrun;
  logic [8:0] out_data;

  int checks = 0, errors = 0;
  logic [10:0] exp_q[$];

  always #2.5 clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV - 1);
  end

  serial_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_clk_pol(cfg_clk_pol),
    .cfg_data_len(cfg_data_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
    .os_tick(os_tick), .xfer_clk(xfer_clk), .rx_line(rx_line),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_par_err(out_par_err), .out_frm_err(out_frm_err), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R8 unexpected character", int'({out_data, out_par_err, out_frm_err}), 0);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk({out_data, out_par_err, out_frm_err} == e, "R3/R4/R5 character and flags",
            int'({out_data, out_par_err, out_frm_err}), int'(e));
      end
    end
  end

  function automatic int eff_len();
    if (cfg_data_len < 4'd5) return 5;
    if (cfg_data_len > 4'd9) return 9;
    return int'(cfg_data_len);
  endfunction

  task automatic put_bit(input logic v);
    if (cfg_sync) begin
      xfer_clk = !cfg_clk_pol;
      rx_line  = v;
      repeat (HALF_X) @(negedge clk);
      xfer_clk = cfg_clk_pol;
      repeat (HALF_X) @(negedge clk);
    end else begin
      rx_line = v;
      repeat (BIT_CLK) @(negedge clk);
    end
  endtask

  task automatic send(input logic [8:0] d, input bit bad_par, input logic s1,
                      input logic s2, input bit expect_it);
    int n;
    logic [8:0] m;
    logic p;
    n = eff_len();
    m = d & 9'((1 << n) - 1);
    p = ^m;
    if (cfg_parity == 2'b11) p = ~p;
    if (bad_par) p = ~p;
    if (expect_it) exp_q.push_back({m, bad_par && cfg_parity[1], !s1});
    put_bit(1'b0);
    for (int i = 0; i < n; i++) put_bit(d[i]);
    if (cfg_parity[1]) put_bit(p);
    put_bit(s1);
    if (cfg_two_stop) put_bit(s2);
    put_bit(1'b1);
    put_bit(1'b1);
  endtask

  task automatic drain(input string req);
    int w = 0;
    while (exp_q.size() != 0 && w < BIT_CLK) begin
      @(negedge clk);
      w++;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] first;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 8 data bits, no parity
    cfg_data_len = 4'd8; cfg_parity = 2'b00;
    send(9'h0A5, 0, 1, 1, 1); drain("R3 async 8N1 A5");
    send(9'h03C, 0, 1, 1, 1); drain("R3 async 8N1 3C");
    // R4 even parity, 5 bits, zero extension, parity error injected
    cfg_data_len = 4'd5; cfg_parity = 2'b10;
    send(9'h1F5, 0, 1, 1, 1); drain("R4 even parity good");
    send(9'h015, 1, 1, 1, 1); drain("R4 even parity error");
    // R4 odd parity, 9 bits
    cfg_data_len = 4'd9; cfg_parity = 2'b11;
    send(9'h1C3, 0, 1, 1, 1); drain("R4 odd parity 9 bits");
    send(9'h155, 1, 1, 1, 1); drain("R4 odd parity error");
    // R3 clamp low and high; R4 mode 01 means no parity
    cfg_data_len = 4'd3; cfg_parity = 2'b01;
    send(9'h0FF, 0, 1, 1, 1); drain("R3 length clamp to 5");
    cfg_data_len = 4'd14; cfg_parity = 2'b00;
    send(9'h12D, 0, 1, 1, 1); drain("R3 length clamp to 9");
    // R5 framing error, then two stop bits with low second stop
    cfg_data_len = 4'd7;
    send(9'h05A, 0, 0, 1, 1); drain("R5 framing error");
    put_bit(1'b1);
    cfg_two_stop = 1'b1;
    send(9'h033, 0, 1, 0, 1); drain("R5 second stop unchecked");
    put_bit(1'b1);
    cfg_two_stop = 1'b0;
    // R2 false start: short low pulse
    rx_line = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    chk(out_valid == 1'b0, "R2 false start gives no character", out_valid, 0);
    cfg_data_len = 4'd8;
    send(9'h081, 0, 1, 1, 1); drain("R2 recovery after false start");
    // R9 config changed mid-frame has no effect on the running frame
    fork
      send(9'h0C6, 0, 1, 1, 1);
      begin repeat (3 * BIT_CLK) @(negedge clk); cfg_data_len = 4'd5; end
    join
    drain("R9 format latched at start");
    cfg_data_len = 4'd8;
    // R6 synchronous, both polarities
    cfg_sync = 1'b1; cfg_clk_pol = 1'b0; xfer_clk = 1'b1;
    repeat (4) @(negedge clk);
    send(9'h0E7, 0, 1, 1, 1); drain("R6 sync falling edge");
    cfg_clk_pol = 1'b1; xfer_clk = 1'b0;
    repeat (4) @(negedge clk);
    cfg_data_len = 4'd9; cfg_parity = 2'b11;
    send(9'h10B, 0, 1, 1, 1); drain("R6 sync rising edge");
    // R7 / R8 back-pressure and overrun (async)
    cfg_sync = 1'b0; cfg_data_len = 4'd8; cfg_parity = 2'b00; rx_line = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    out_ready = 1'b0;
    first = 9'h04E;
    send(first, 0, 1, 1, 1);
    chk(out_valid == 1'b1, "R7 valid held", out_valid, 1);
    chk(overrun == 1'b0, "R8 no overrun yet", overrun, 0);
    send(9'h0B1, 0, 1, 1, 0);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    chk(out_data == first, "R8 older data kept", out_data, first);
    out_ready = 1'b1;
    drain("R7 delivery after release");
    @(negedge clk);
    chk(overrun == 1'b0, "R8 overrun cleared", overrun, 0);
    chk(out_valid == 1'b0, "R7 valid dropped", out_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule